// File: doc/BRIEF.md
# Log-Domain FM Operator Engine

This block computes one FM operator sample per time slot. Six channels of four operators each are evaluated in a fixed rotation of 24 slots, and a new slot opens every `DIV` clock cycles. For the operator in the current slot, the block adds that operator's increment into its 20-bit phase accumulator and takes the top ten bits as the phase. It looks up the attenuation of a half-wave sine in the log domain, adds the envelope attenuation, and converts the sum back to linear magnitude through an exponent table and a barrel shift. It then applies the sign from the phase. When the fourth operator of a channel finishes, the block sums the carrier operators selected by the channel's algorithm number and issues the channel sample.

Surrounding logic reads `slot_idx` and presents the increment, attenuation, algorithm and sample-mode flag for that slot. A small state machine sequences every slot: WAIT holds until the pacing tick, then moves to ACCUM. ACCUM samples the inputs and updates the accumulator, then moves to SINE, or back to WAIT when the slot is skipped. SINE forms the table index and moves to POW. POW writes the operator sample and moves to MIX after the fourth operator of a channel, or to WAIT otherwise. MIX writes the channel sample and returns to WAIT.

Top module: `fm_op_engine`

## Requirements
- R1: While reset is held, `op_valid`, `ch_valid`, `slot_idx`, `op_id`, `op_out`, `ch_id` and `ch_out` are all zero, and every phase accumulator is cleared.
- R2: Slots open once every DIV (default 6) cycles and `slot_idx` steps 0,1,…,23,0. Every slot that is not skipped yields exactly one single-cycle `op_valid` pulse, DIV cycles after the previous one. `op_valid` and `ch_valid` are never high in the same cycle.
- R3: Each evaluation adds `op_inc` into that operator's 20-bit accumulator, wrapping modulo 2^20. The phase used for the sample is accumulator bits [19:10], taken after the add.
- R4: The sine attenuation for phase bits [8:0] = i is round(−log2(sin((2i+1)·π/1024))·256).
- R5: The table index is the sine attenuation plus `op_att`, clipped to 8191 when the sum exceeds it.
- R6: For index x with f = x[7:0] and s = x[12:8], the magnitude is round(2^(−(f+1)/256)·2048). That value is shifted left by (2−s) when s < 2 and right by (s−2) otherwise.
- R7: `op_out` is the two's-complement negative of the magnitude when phase bit 9 is 1, and the magnitude itself when phase bit 9 is 0.
- R8: For algorithm numbers 0 to 3, the channel sample equals the channel's fourth operator (operator index 3 within the channel).
- R9: For algorithm 4, the channel sample is the sum of the second and fourth operators (indices 1 and 3).
- R10: Algorithms 5 and 6 sum operator indices 1, 2 and 3, and algorithm 7 sums all four, all as signed 18-bit values without wrap.
- R11: While `dac_mode` is 1, the slots of channel 5 (slots 20–23) are skipped. They produce no `op_valid`, produce no `ch_valid`, and leave those accumulators unchanged.
- R12: `op_id` carries the slot number of the operator sample. `ch_id` carries the channel number, which is the slot number divided by four, of the channel sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_idx | output | 5 | Slot currently being served; the inputs below must describe this slot |
| op_inc | input | 20 | Phase increment of the current slot's operator |
| op_att | input | 13 | Envelope attenuation of the current slot's operator (log units, 1/256 octave) |
| ch_alg | input | 3 | Algorithm number of the current slot's channel |
| dac_mode | input | 1 | When 1, channel 5 slots are skipped |
| op_valid | output | 1 | One-cycle strobe: `op_out` and `op_id` are new |
| op_id | output | 5 | Slot number of the operator sample |
| op_out | output | 16 | Signed operator sample |
| ch_valid | output | 1 | One-cycle strobe: `ch_out` and `ch_id` are new |
| ch_id | output | 3 | Channel number of the channel sample |
| ch_out | output | 18 | Signed channel sample |

## Verification
Some properties are checked on every cycle. The slot counter may only step by one with wrap. The two strobes never coincide. Every channel strobe directly follows the strobe of a fourth operator and carries that operator's channel number. Every operator sample stays within the magnitude range of the exponent table. The numerical content cannot be checked this way: the rounding of both tables, the clipping of the index, the sign, the carrier selection for each algorithm, and the skipped and unchanged channel-5 phases while sample mode is on. Only the bench's scenarios can show these, by comparing every sample with a model built from the formulas.

// File: rtl/fm_pkg.sv
package fm_pkg;
    localparam int OPS      = 4;
    localparam int SIN_AW   = 9;
    localparam int SIN_N    = 1 << SIN_AW;
    localparam int SIN_W    = 12;
    localparam int EXP_FW   = 8;
    localparam int EXP_N    = 1 << EXP_FW;
    localparam int EXP_W    = 11;
    localparam int IDX_W    = 13;
    localparam int MAG_W    = EXP_W + 2;
    localparam real HALF_PI_X2 = 3.14159265358979;

    typedef enum logic [2:0] {
        S_WAIT,
        S_ACCUM,
        S_SINE,
        S_POW,
        S_MIX
    } op_state_e;

    // log2 attenuation of a half sine wave, 4.8 fixed point
    function automatic logic [SIN_N*SIN_W-1:0] build_sine();
        logic [SIN_N*SIN_W-1:0] t;
        real x;
        int v;
        t = '0;
        for (int i = 0; i < SIN_N; i++) begin
            x = $sin((real'(2*i+1) / real'(2*SIN_N)) * HALF_PI_X2);
            v = $rtoi(-($ln(x) / $ln(2.0)) * 256.0 + 0.5);
            t[i*SIN_W +: SIN_W] = v[SIN_W-1:0];
        end
        return t;
    endfunction

    // fractional exponent 2^-(f+1)/256 with 11 fraction bits
    function automatic logic [EXP_N*EXP_W-1:0] build_exp();
        logic [EXP_N*EXP_W-1:0] t;
        int v;
        t = '0;
        for (int f = 0; f < EXP_N; f++) begin
            v = $rtoi($pow(2.0, -real'(f+1) / 256.0) * 2048.0 + 0.5);
            t[f*EXP_W +: EXP_W] = v[EXP_W-1:0];
        end
        return t;
    endfunction
endpackage

// File: rtl/fm_logsin_rom.sv
module fm_logsin_rom
    import fm_pkg::*;
(
    input  logic [SIN_AW-1:0] addr,
    output logic [SIN_W-1:0]  atten
);
    localparam logic [SIN_N*SIN_W-1:0] SIN_TBL = build_sine();

    always_comb atten = SIN_TBL[addr*SIN_W +: SIN_W];
endmodule

// File: rtl/fm_exp_conv.sv
module fm_exp_conv
    import fm_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    output logic [MAG_W-1:0] mag
);
    localparam logic [EXP_N*EXP_W-1:0] EXP_TBL = build_exp();
    localparam int SH_W = IDX_W - EXP_FW;

    logic [EXP_W-1:0] frac;
    logic [SH_W-1:0]  shamt;
    logic [MAG_W-1:0] scaled;

    always_comb begin
        frac   = EXP_TBL[idx[EXP_FW-1:0]*EXP_W +: EXP_W];
        shamt  = idx[IDX_W-1:EXP_FW];
        // pre-scale by 4 so one right shift covers both directions
        scaled = {frac, 2'b00};
        mag    = scaled >> shamt;
    end
endmodule

// File: rtl/fm_mixer.sv
module fm_mixer
    import fm_pkg::*;
#(
    parameter int OUT_W = 16,
    parameter int CH_W  = 18
) (
    input  logic [2:0]           alg,
    input  logic [OPS*OUT_W-1:0] ops_flat,
    output logic [CH_W-1:0]      mix
);
    logic [OPS-1:0]  carrier;
    logic [CH_W-1:0] acc;

    always_comb begin
        unique case (alg)
            3'd0, 3'd1, 3'd2, 3'd3: carrier = 4'b1000;
            3'd4:                   carrier = 4'b1010;
            3'd5, 3'd6:             carrier = 4'b1110;
            default:                carrier = 4'b1111;
        endcase
        acc = '0;
        for (int k = 0; k < OPS; k++) begin
            if (carrier[k]) begin
                acc = acc + {{(CH_W-OUT_W){ops_flat[k*OUT_W+OUT_W-1]}},
                             ops_flat[k*OUT_W +: OUT_W]};
            end
        end
        mix = acc;
    end
endmodule

// File: rtl/fm_op_engine.sv
module fm_op_engine
    import fm_pkg::*;
#(
    parameter int DIV   = 6,
    parameter int NCH   = 6,
    parameter int PH_W  = 20,
    parameter int ATT_W = 13,
    parameter int OUT_W = 16,
    parameter int CH_W  = 18
) (
    input  logic                           clk,
    input  logic                           rst_n,
    output logic [$clog2(NCH*OPS)-1:0]     slot_idx,
    input  logic [PH_W-1:0]                op_inc,
    input  logic [ATT_W-1:0]               op_att,
    input  logic [2:0]                     ch_alg,
    input  logic                           dac_mode,
    output logic                           op_valid,
    output logic [$clog2(NCH*OPS)-1:0]     op_id,
    output logic [OUT_W-1:0]               op_out,
    output logic                           ch_valid,
    output logic [$clog2(NCH)-1:0]         ch_id,
    output logic [CH_W-1:0]                ch_out
);
    localparam int NSLOT  = NCH * OPS;
    localparam int SLOT_W = $clog2(NSLOT);
    localparam int CHI_W  = $clog2(NCH);
    localparam int DIV_W  = $clog2(DIV);
    localparam int SUM_W  = ((SIN_W > ATT_W) ? SIN_W : ATT_W) + 1;
    localparam int IDX_MAX = (1 << IDX_W) - 1;
    localparam int PH_LSB = PH_W - 10;

    op_state_e st, st_nx;

    logic [DIV_W-1:0]  div_q;
    logic              tick;
    logic [SLOT_W-1:0] slot_q, slot_nx;
    logic              skip, last_op;
    logic [PH_W-1:0]   acc_q [NSLOT];
    logic [PH_W-1:0]   acc_nx;
    logic [9:0]        ph_q;
    logic [ATT_W-1:0]  att_q;
    logic [2:0]        alg_q;
    logic [IDX_W-1:0]  idx_q, idx_sat;
    logic              sgn_q;
    logic [SIN_W-1:0]  sin_att;
    logic [SUM_W-1:0]  sum_w;
    logic [MAG_W-1:0]  mag;
    logic [OUT_W-1:0]  op_val;
    logic [OUT_W-1:0]  buf_q [OPS];
    logic [OPS*OUT_W-1:0] ops_flat;
    logic [CH_W-1:0]   mix;

    fm_logsin_rom u_sin (.addr(ph_q[SIN_AW-1:0]), .atten(sin_att));
    fm_exp_conv   u_exp (.idx(idx_q), .mag(mag));
    fm_mixer #(.OUT_W(OUT_W), .CH_W(CH_W)) u_mix (
        .alg(alg_q), .ops_flat(ops_flat), .mix(mix));

    for (genvar g = 0; g < OPS; g++) begin : g_flat
        assign ops_flat[g*OUT_W +: OUT_W] = buf_q[g];
    end

    always_comb begin
        tick    = (div_q == DIV_W'(DIV-1));
        slot_nx = (slot_q == SLOT_W'(NSLOT-1)) ? '0 : slot_q + 1'b1;
        skip    = dac_mode && (slot_q[SLOT_W-1:2] == CHI_W'(NCH-1));
        last_op = (slot_q[1:0] == 2'b11);
        acc_nx  = acc_q[slot_q] + op_inc;
        sum_w   = SUM_W'(sin_att) + SUM_W'(att_q);
        idx_sat = (sum_w > SUM_W'(IDX_MAX)) ? '1 : sum_w[IDX_W-1:0];
        op_val  = sgn_q ? (OUT_W'(0) - OUT_W'(mag)) : OUT_W'(mag);
    end

    always_comb begin
        unique case (st)
            S_WAIT:  st_nx = tick ? S_ACCUM : S_WAIT;
            S_ACCUM: st_nx = skip ? S_WAIT : S_SINE;
            S_SINE:  st_nx = S_POW;
            S_POW:   st_nx = last_op ? S_MIX : S_WAIT;
            S_MIX:   st_nx = S_WAIT;
            default: st_nx = S_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= S_WAIT;
        else        st <= st_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q    <= '0;
            slot_q   <= '0;
            ph_q     <= '0;
            att_q    <= '0;
            alg_q    <= '0;
            idx_q    <= '0;
            sgn_q    <= 1'b0;
            op_valid <= 1'b0;
            op_id    <= '0;
            op_out   <= '0;
            ch_valid <= 1'b0;
            ch_id    <= '0;
            ch_out   <= '0;
            for (int i = 0; i < NSLOT; i++) acc_q[i] <= '0;
            for (int k = 0; k < OPS; k++)   buf_q[k] <= '0;
        end else begin
            div_q    <= tick ? '0 : div_q + 1'b1;
            op_valid <= 1'b0;
            ch_valid <= 1'b0;
            unique case (st)
                S_WAIT: ;
                S_ACCUM: begin
                    if (skip) begin
                        slot_q <= slot_nx;
                    end else begin
                        acc_q[slot_q] <= acc_nx;
                        ph_q  <= acc_nx[PH_W-1:PH_LSB];
                        att_q <= op_att;
                        alg_q <= ch_alg;
                    end
                end
                S_SINE: begin
                    idx_q <= idx_sat;
                    sgn_q <= ph_q[9];
                end
                S_POW: begin
                    op_out   <= op_val;
                    op_valid <= 1'b1;
                    op_id    <= slot_q;
                    buf_q[slot_q[1:0]] <= op_val;
                    if (!last_op) slot_q <= slot_nx;
                end
                S_MIX: begin
                    ch_out   <= mix;
                    ch_valid <= 1'b1;
                    ch_id    <= slot_q[SLOT_W-1:2];
                    slot_q   <= slot_nx;
                end
                default: ;
            endcase
        end
    end

    assign slot_idx = slot_q;

    // R2
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_valid && ch_valid));

    // R2
    slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(slot_q) |-> slot_q == (($past(slot_q) == SLOT_W'(NSLOT-1)) ? '0 : $past(slot_q) + 1'b1));

    // R8
    ch_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ch_valid |-> ($past(op_valid) && ($past(op_id[1:0]) == 2'b11)));

    // R12
    ch_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ch_valid |-> (ch_id == $past(op_id[SLOT_W-1:2])));

    // R6
    op_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |-> ($signed(op_out) < $signed(OUT_W'(1 << MAG_W)) &&
                      $signed(op_out) > -$signed(OUT_W'(1 << MAG_W))));
endmodule

// File: tb/tb_fm_op_engine.sv
`timescale 1ns/1ps
module tb_fm_op_engine;
    localparam int NS  = 24;
    localparam int DIV = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  slot_idx;
    logic [19:0] op_inc;
    logic [12:0] op_att;
    logic [2:0]  ch_alg;
    logic        dac_mode = 1'b0;
    logic        op_valid, ch_valid;
    logic [4:0]  op_id;
    logic [15:0] op_out;
    logic [2:0]  ch_id;
    logic [17:0] ch_out;

    logic [19:0] inc_arr [NS];
    logic [12:0] att_arr [NS];
    logic [2:0]  alg_arr [6];

    int tot = 0, bad = 0;
    int cyc = 0, n_op = 0, n_hi = 0, n_ch5 = 0, n_neg = 0, n_pos = 0;
    string cur_tag = "R3";
    bit done = 0;

    logic [19:0] m_acc [NS];
    int          m_op [NS];
    int          exp_id = 0, prev_id = -1, prev_cyc = 0;

    always #2.5 clk = ~clk;

    assign op_inc = inc_arr[slot_idx];
    assign op_att = att_arr[slot_idx];
    assign ch_alg = alg_arr[slot_idx[4:2]];

    fm_op_engine dut (
        .clk(clk), .rst_n(rst_n), .slot_idx(slot_idx), .op_inc(op_inc),
        .op_att(op_att), .ch_alg(ch_alg), .dac_mode(dac_mode),
        .op_valid(op_valid), .op_id(op_id), .op_out(op_out),
        .ch_valid(ch_valid), .ch_id(ch_id), .ch_out(ch_out));

    task automatic check(input bit ok, input string tag, input longint act, input longint expv);
        tot++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, expv);
        end
    endtask

    function automatic int ref_sine(int i);
        real x;
        x = $sin((real'(2*i+1) / 1024.0) * 3.14159265358979);
        return $rtoi(-($ln(x) / $ln(2.0)) * 256.0 + 0.5);
    endfunction

    function automatic int ref_pow(int x);
        int f, s, fr;
        f  = x % 256;
        s  = x / 256;
        fr = $rtoi($pow(2.0, -real'(f+1) / 256.0) * 2048.0 + 0.5);
        if (s < 2) return fr << (2 - s);
        return fr >> (s - 2);
    endfunction

    function automatic int ref_op(logic [19:0] acc, int att);
        int ph, sum, m;
        ph  = int'(acc >> 10);
        sum = ref_sine(ph % 512) + att;
        if (sum > 8191) sum = 8191;
        m = ref_pow(sum);
        return (ph >= 512) ? -m : m;
    endfunction

    // monitor: model updated at every observed operator strobe
    always @(negedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NS; i++) begin m_acc[i] = '0; m_op[i] = 0; end
            exp_id = 0; prev_id = -1; cyc = 0;
        end else begin
            cyc++;
            if (op_valid) begin
                int id, e;
                id = int'(op_id);
                n_op++;
                if (id >= 20) n_hi++;
                check(id == exp_id, "R12 op_id", id, exp_id);
                if (prev_id >= 0 && id == (prev_id + 1) % NS)
                    check(cyc - prev_cyc == DIV, "R2 spacing", cyc - prev_cyc, DIV);
                m_acc[id] = m_acc[id] + inc_arr[id];
                e = ref_op(m_acc[id], int'(att_arr[id]));
                check($signed(op_out) == e, cur_tag, $signed(op_out), e);
                if (e < 0) n_neg++;
                if (e > 0) n_pos++;
                m_op[id] = e;
                prev_id = id; prev_cyc = cyc;
                exp_id = (id + 1) % NS;
                if (dac_mode && exp_id == 20) exp_id = 0;
            end
            if (ch_valid) begin
                int c, a, e;
                c = int'(ch_id);
                a = int'(alg_arr[c]);
                if (c == 5) n_ch5++;
                check(c == prev_id / 4, "R12 ch_id", c, prev_id / 4);
                if (a < 4) begin
                    e = m_op[c*4+3];
                    check($signed(ch_out) == e, "R8 mix", $signed(ch_out), e);
                end else if (a == 4) begin
                    e = m_op[c*4+1] + m_op[c*4+3];
                    check($signed(ch_out) == e, "R9 mix", $signed(ch_out), e);
                end else begin
                    e = m_op[c*4+1] + m_op[c*4+2] + m_op[c*4+3] + ((a == 7) ? m_op[c*4] : 0);
                    check($signed(ch_out) == e, "R10 mix", $signed(ch_out), e);
                end
            end
        end
    end

    task automatic run_rounds(input int n);
        repeat (n * NS * DIV) @(posedge clk);
    endtask

    task automatic restart();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        check(!op_valid && !ch_valid, "R1 strobes", {op_valid, ch_valid}, 0);
        check(slot_idx == 0 && op_id == 0 && ch_id == 0, "R1 ids", slot_idx, 0);
        check(op_out == 0 && ch_out == 0, "R1 data", op_out, 0);
    endtask

    task automatic t_table();
        int n0;
        cur_tag = "R4 sine";
        for (int i = 0; i < NS; i++) begin
            inc_arr[i] = 20'((i + 1) << 10) + 20'(i * 37);
            att_arr[i] = '0;
        end
        for (int c = 0; c < 6; c++) alg_arr[c] = 3'(c % 4);
        restart();
        n0 = n_op;
        run_rounds(3);
        check(n_op - n0 >= 70 && n_op - n0 <= 72, "R2 count", n_op - n0, 72);
    endtask

    task automatic t_sign();
        cur_tag = "R7 sign";
        for (int i = 0; i < NS; i++) inc_arr[i] = 20'h80000 + 20'(i << 11);
        n_neg = 0; n_pos = 0;
        restart();
        run_rounds(3);
        check(n_neg > 0, "R7 negatives", n_neg, 1);
        check(n_pos > 0, "R7 positives", n_pos, 1);
    endtask

    task automatic t_wrap();
        cur_tag = "R3 accum";
        for (int i = 0; i < NS; i++) inc_arr[i] = 20'hFFFFF - 20'(i * 4099);
        restart();
        run_rounds(4);
    endtask

    task automatic t_atten();
        cur_tag = "R5 atten";
        for (int i = 0; i < NS; i++) begin
            inc_arr[i] = 20'(i * 9001 + 3);
            att_arr[i] = (i % 3 == 0) ? 13'd8191 : 13'(i * 341);
        end
        restart();
        run_rounds(3);
    endtask

    task automatic t_exp();
        cur_tag = "R6 power";
        for (int i = 0; i < NS; i++) begin
            inc_arr[i] = 20'h40000;
            att_arr[i] = 13'(i * 256 + i);
        end
        restart();
        run_rounds(2);
    endtask

    task automatic t_alg();
        cur_tag = "R10 ops";
        alg_arr[0] = 3'd4; alg_arr[1] = 3'd5; alg_arr[2] = 3'd6;
        alg_arr[3] = 3'd7; alg_arr[4] = 3'd2; alg_arr[5] = 3'd4;
        for (int i = 0; i < NS; i++) begin
            inc_arr[i] = 20'(i * 23456 + 1111);
            att_arr[i] = 13'(i * 13);
        end
        restart();
        run_rounds(3);
    endtask

    task automatic t_dac();
        int h0, c0;
        cur_tag = "R11 phase";
        for (int i = 0; i < NS; i++) inc_arr[i] = 20'(i * 5557 + 2049);
        restart();
        run_rounds(1);
        do @(negedge clk); while (!(ch_valid && ch_id == 0));
        dac_mode = 1'b1;
        h0 = n_hi; c0 = n_ch5;
        run_rounds(2);
        check(n_hi == h0, "R11 no ch5 ops", n_hi - h0, 0);
        check(n_ch5 == c0, "R11 no ch5 mix", n_ch5 - c0, 0);
        do @(negedge clk); while (!(ch_valid && ch_id == 0));
        dac_mode = 1'b0;
        run_rounds(2);
        check(n_hi > h0, "R11 resumed", n_hi - h0, 8);
    endtask

    initial begin
        for (int i = 0; i < NS; i++) begin inc_arr[i] = '0; att_arr[i] = '0; end
        for (int c = 0; c < 6; c++) alg_arr[c] = '0;
        t_reset();
        t_table();
        t_sign();
        t_wrap();
        t_atten();
        t_exp();
        t_alg();
        t_dac();
        done = 1;
        $display("  test done: total=%0d bad=%0d", tot, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tot++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", tot, bad);
            $finish;
        end
    end
endmodule